// File: doc/BRIEF.md
# Master-Mode Frame Sync Generator

This block drives the frame timing of a serial 2B+D data port when that port is the clock master. It gets a one-cycle enable for each bit period. It counts bit positions around a frame of configurable length. It also produces two 8 kHz strobes. The first strobe marks the first 8-bit time slot of the frame and serves both directions. The second strobe marks the slot that carries the second B channel. The bit-position count goes out on a port so that the time-division-multiplexed data port can share it and needs no counter of its own.

Two alignment modes are available. In non-delayed alignment, each strobe stays high for the whole of its slot. In delayed alignment, each strobe is one bit wide and falls in the bit just before its slot.

The layout selection sets where the second slot sits. It also limits the alignment modes:
- Layout 2 always runs delayed.
- Layout 4 always runs non-delayed.

Layout and alignment are taken up only at a frame boundary, so a frame never holds a mix of modes.

A small state machine makes the strobes. It has these states:
- `ST_IDLE`: after reset, before the first bit.
- `ST_LEAD_A`: the lead bit before the first slot (delayed alignment).
- `ST_SLOT_A`: inside the first slot (non-delayed alignment).
- `ST_LEAD_B`: the lead bit before the second slot (delayed alignment).
- `ST_SLOT_B`: inside the second slot (non-delayed alignment).
- `ST_REST`: any other bit.

The state changes only on an enabled bit. The next state comes from the next bit position and the alignment in force:
- Non-delayed alignment: REST/IDLE→SLOT_A at bit 0, SLOT_A→REST after the slot, REST→SLOT_B at the second slot's start, and SLOT_B→REST after it. When the slots touch, the machine goes SLOT_A→SLOT_B directly.
- Delayed alignment: REST/IDLE→LEAD_B at the bit before the second slot, LEAD_B→REST, REST→LEAD_A at the last bit of the frame, and LEAD_A→REST at bit 0.

Top module: `fsync_gen`

## Requirements
- R1: After reset, `bit_pos` equals FRAME_LEN-1 and both strobes are low. This holds until the first cycle with `bit_en` high.
- R2: On each cycle with `bit_en` high, `bit_pos` advances by one. It wraps from FRAME_LEN-1 to 0. It does not change on other cycles.
- R3: With non-delayed alignment, `sync_a` is high exactly while `bit_pos` is in 0..7.
- R4: With non-delayed alignment, `sync_b` is high exactly while `bit_pos` is in 8..15.
- R5: With delayed alignment, `sync_a` is high only while `bit_pos` equals FRAME_LEN-1.
- R6: With delayed alignment, `sync_b` is high only in the bit before the second slot. That bit is `bit_pos` 7 for layout codes 2'b00 and 2'b10, and 9 for code 2'b01, whose second slot starts at bit 10.
- R7: Layout code 2'b01 (layout 2) always uses delayed alignment, whatever the value of `delayed_mode`.
- R8: Layout code 2'b11 (layout 4) always uses non-delayed alignment, whatever the value of `delayed_mode`.
- R9: A change of `layout_sel` or `delayed_mode` takes effect only from the next bit 0. The rest of the current frame keeps the old timing.
- R10: The strobes and `bit_pos` stay stable on cycles where `bit_en` is low.
- R11: `sync_a` and `sync_b` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per bit period |
| layout_sel | input | 2 | Layout code: 00=layout 1, 01=layout 2, 10=layout 3, 11=layout 4 |
| delayed_mode | input | 1 | 1 selects delayed (one-bit lead) alignment |
| sync_a | output | 1 | First-slot frame strobe |
| sync_b | output | 1 | Second-slot strobe |
| bit_pos | output | $clog2(FRAME_LEN) | Current bit position in the frame |

## Verification
The hardest case to reach is a layout or alignment change in the middle of a frame. The old timing has to hold for the rest of that frame, and the new timing has to start exactly at the wrap. The stimulus gets there by stepping to bit 20, switching from non-delayed to delayed alignment there, and then checking every remaining bit against the old mode and every bit after the wrap against the new one. The forced modes of layouts 2 and 4 are driven with the opposite `delayed_mode` request, so that the override is visible at the strobes.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        LAY_1 = 2'b00,
        LAY_2 = 2'b01,
        LAY_3 = 2'b10,
        LAY_4 = 2'b11
    } layout_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_A,
        ST_SLOT_A,
        ST_LEAD_B,
        ST_SLOT_B,
        ST_REST
    } fsg_state_e;

endpackage

// File: rtl/fsg_bit_counter.sv
module fsg_bit_counter #(
    parameter int FRAME_LEN = 256,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] nxt_o,
    output logic          frame_start_o
);

    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cnt_q;

    // The position the next enabled bit will take.
    always_comb begin
        if (cnt_q == LAST) begin
            nxt_o = '0;
        end else begin
            nxt_o = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
        end else if (bit_en) begin
            cnt_q <= nxt_o;
        end
    end

    assign cnt_o         = cnt_q;
    assign frame_start_o = bit_en && (nxt_o == '0);

    // R2: the count returns to zero after the last bit.
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cnt_q == LAST) |=> (cnt_q == '0));

    // R10: the count holds on cycles without an enable.
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt_q));

endmodule

// File: rtl/fsg_mode_sel.sv
module fsg_mode_sel
    import fsg_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [1:0]    layout_i,
    input  logic          delayed_i,
    output logic          nxt_delayed_o,
    output logic [CW-1:0] nxt_sb_o,
    output logic          cur_delayed_o
);

    localparam logic [CW-1:0] SB_PLAIN = CW'(SLOT_BITS);
    localparam logic [CW-1:0] SB_GAP   = CW'(SLOT_BITS + 2);

    logic          res_delayed;
    logic [CW-1:0] res_sb;
    logic          lat_delayed_q;
    logic [CW-1:0] lat_sb_q;

    // Resolve the requested alignment against what each layout allows.
    always_comb begin
        res_delayed = delayed_i;
        res_sb      = SB_PLAIN;
        unique case (layout_e'(layout_i))
            LAY_2: begin
                res_delayed = 1'b1;
                res_sb      = SB_GAP;
            end
            LAY_4:   res_delayed = 1'b0;
            LAY_1,
            LAY_3:   res_delayed = delayed_i;
            default: res_delayed = delayed_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_delayed_q <= 1'b0;
            lat_sb_q      <= SB_PLAIN;
        end else if (frame_start) begin
            lat_delayed_q <= res_delayed;
            lat_sb_q      <= res_sb;
        end
    end

    // The first bit of a frame already decodes with the new settings.
    assign nxt_delayed_o = frame_start ? res_delayed : lat_delayed_q;
    assign nxt_sb_o      = frame_start ? res_sb      : lat_sb_q;
    assign cur_delayed_o = lat_delayed_q;

    // R7: layout 2 forces delayed alignment.
    p_l2_delayed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && layout_i == LAY_2) |=> lat_delayed_q);

    // R8: layout 4 forces non-delayed alignment.
    p_l4_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && layout_i == LAY_4) |=> !lat_delayed_q);

    // R9: the latched alignment moves only at a frame boundary.
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(lat_delayed_q) && $stable(lat_sb_q)));

endmodule

// File: rtl/fsg_fsm.sv
module fsg_fsm
    import fsg_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    parameter int SLOT_BITS = 8,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [CW-1:0] nxt,
    input  logic          nxt_delayed,
    input  logic [CW-1:0] nxt_sb,
    output logic          sync_a_o,
    output logic          sync_b_o
);

    localparam logic [CW-1:0] LAST   = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] SLOT_W = CW'(SLOT_BITS);

    fsg_state_e state_q;
    fsg_state_e state_d;
    logic [CW-1:0] sb_lead;
    logic [CW-1:0] sb_end;

    assign sb_lead = nxt_sb - CW'(1);
    assign sb_end  = nxt_sb + SLOT_W;

    // Next state from the bit about to start.
    always_comb begin
        state_d = ST_REST;
        if (nxt_delayed) begin
            if (nxt == LAST) begin
                state_d = ST_LEAD_A;
            end else if (nxt == sb_lead) begin
                state_d = ST_LEAD_B;
            end
        end else begin
            if (nxt < SLOT_W) begin
                state_d = ST_SLOT_A;
            end else if (nxt >= nxt_sb && nxt < sb_end) begin
                state_d = ST_SLOT_B;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (bit_en) begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        sync_a_o = 1'b0;
        sync_b_o = 1'b0;
        unique case (state_q)
            ST_LEAD_A,
            ST_SLOT_A: sync_a_o = 1'b1;
            ST_LEAD_B,
            ST_SLOT_B: sync_b_o = 1'b1;
            ST_IDLE,
            ST_REST:   sync_a_o = 1'b0;
            default:   sync_a_o = 1'b0;
        endcase
    end

    // R11: the two strobes never overlap.
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_a_o && sync_b_o));

    // R5: the delayed first-slot strobe lasts one bit.
    p_lead_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD_A && bit_en) |=> (state_q != ST_LEAD_A));

    // R10: the state holds without an enable.
    p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(state_q));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
    parameter int FRAME_LEN = 256,
    parameter int SLOT_BITS = 8,
    localparam int CW       = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [1:0]    layout_sel,
    input  logic          delayed_mode,
    output logic          sync_a,
    output logic          sync_b,
    output logic [CW-1:0] bit_pos
);

    logic [CW-1:0] nxt;
    logic          frame_start;
    logic          nxt_delayed;
    logic [CW-1:0] nxt_sb;
    logic          cur_delayed;

    fsg_bit_counter #(
        .FRAME_LEN (FRAME_LEN),
        .CW        (CW)
    ) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en        (bit_en),
        .cnt_o         (bit_pos),
        .nxt_o         (nxt),
        .frame_start_o (frame_start)
    );

    fsg_mode_sel #(
        .SLOT_BITS (SLOT_BITS),
        .CW        (CW)
    ) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .layout_i      (layout_sel),
        .delayed_i     (delayed_mode),
        .nxt_delayed_o (nxt_delayed),
        .nxt_sb_o      (nxt_sb),
        .cur_delayed_o (cur_delayed)
    );

    fsg_fsm #(
        .FRAME_LEN (FRAME_LEN),
        .SLOT_BITS (SLOT_BITS),
        .CW        (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .nxt         (nxt),
        .nxt_delayed (nxt_delayed),
        .nxt_sb      (nxt_sb),
        .sync_a_o    (sync_a),
        .sync_b_o    (sync_b)
    );

    // R3: a non-delayed first-slot strobe starts at bit 0.
    p_plain_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_a) && !cur_delayed) |-> (bit_pos == '0));

    // R1: no strobe before the first enabled bit after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos == CW'(FRAME_LEN - 1) && !cur_delayed) |-> !sync_a);

endmodule

// File: tb/sim_fsync_gen.sv
`timescale 1ns/1ps
module sim_fsync_gen;

    localparam int L  = 256;
    localparam int CW = $clog2(L);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic [1:0]    layout_sel = 2'b00;
    logic          delayed_mode = 1'b0;
    logic          sync_a;
    logic          sync_b;
    logic [CW-1:0] bit_pos;

    fsync_gen #(.FRAME_LEN(L), .SLOT_BITS(8)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .layout_sel   (layout_sel),
        .delayed_mode (delayed_mode),
        .sync_a       (sync_a),
        .sync_b       (sync_b),
        .bit_pos      (bit_pos)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int       m_pos;
    bit       m_started;
    bit       m_del;
    int       m_sb;
    logic [1:0] m_lay;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic latch_model();
        m_lay = layout_sel;
        if (layout_sel == 2'b01)      m_del = 1'b1;
        else if (layout_sel == 2'b11) m_del = 1'b0;
        else                          m_del = delayed_mode;
        m_sb = (layout_sel == 2'b01) ? 10 : 8;
    endtask

    function automatic string tag_a();
        if (m_lay == 2'b01) return "R7";
        if (m_lay == 2'b11) return "R8";
        return m_del ? "R5" : "R3";
    endfunction

    function automatic string tag_b();
        if (m_lay == 2'b01) return "R7";
        if (m_lay == 2'b11) return "R8";
        return m_del ? "R6" : "R4";
    endfunction

    task automatic compare(input string force_tag);
        bit ea, eb;
        ea = 1'b0;
        eb = 1'b0;
        if (m_started) begin
            if (m_del) begin
                ea = (m_pos == L - 1);
                eb = (m_pos == m_sb - 1);
            end else begin
                ea = (m_pos < 8);
                eb = (m_pos >= m_sb) && (m_pos < m_sb + 8);
            end
        end
        chk(bit_pos == CW'(m_pos), "R2", "bit_pos", int'(bit_pos), m_pos);
        chk(sync_a == ea, (force_tag != "") ? force_tag : tag_a(), "sync_a",
            int'(sync_a), int'(ea));
        chk(sync_b == eb, (force_tag != "") ? force_tag : tag_b(), "sync_b",
            int'(sync_b), int'(eb));
        chk(!(sync_a && sync_b), "R11", "overlap", int'(sync_a && sync_b), 0);
    endtask

    // One enabled bit, then compare once the edge has passed.
    task automatic tick(input string force_tag);
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        m_pos = (m_pos + 1) % L;
        m_started = 1'b1;
        if (m_pos == 0) latch_model();
        compare(force_tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_pos = L - 1;
        m_started = 1'b0;
        m_del = 1'b0;
        m_sb = 8;
        m_lay = 2'b00;
        @(negedge clk);
        chk(bit_pos == CW'(L - 1), "R1", "reset bit_pos", int'(bit_pos), L - 1);
        chk(!sync_a && !sync_b, "R1", "reset strobes", int'({sync_a, sync_b}), 0);
        repeat (3) @(negedge clk);
        chk(bit_pos == CW'(L - 1), "R1", "idle bit_pos", int'(bit_pos), L - 1);
        chk(!sync_a && !sync_b, "R1", "idle strobes", int'({sync_a, sync_b}), 0);
    endtask

    task automatic t_frames(input logic [1:0] lay, input logic del, input int n);
        layout_sel = lay;
        delayed_mode = del;
        for (int i = 0; i < n * L; i++) tick("");
    endtask

    // R9: switch alignment in mid-frame; the old timing must hold to the wrap.
    task automatic t_midchange();
        layout_sel = 2'b00;
        delayed_mode = 1'b0;
        while (m_pos != 20) tick("");
        delayed_mode = 1'b1;
        while (m_pos != L - 1) tick("R9");
        for (int i = 0; i < L; i++) tick("");
    endtask

    // R10: no enable for several cycles; everything holds.
    task automatic t_stall();
        logic [CW-1:0] p0;
        logic a0, b0;
        layout_sel = 2'b00;
        delayed_mode = 1'b0;
        while (m_pos != 3) tick("");
        p0 = bit_pos;
        a0 = sync_a;
        b0 = sync_b;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(bit_pos == p0, "R10", "stall bit_pos", int'(bit_pos), int'(p0));
            chk(sync_a == a0 && sync_b == b0, "R10", "stall strobes",
                int'({sync_a, sync_b}), int'({a0, b0}));
        end
        while (m_pos != L - 1) tick("");
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_frames(2'b00, 1'b0, 2);
        t_frames(2'b00, 1'b1, 2);
        t_frames(2'b10, 1'b1, 1);
        t_frames(2'b10, 1'b0, 1);
        t_frames(2'b01, 1'b0, 2);
        t_frames(2'b11, 1'b1, 2);
        t_midchange();
        t_stall();
        t_reset();
        t_frames(2'b00, 1'b1, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule